// File: doc/BRIEF.md
# DDR2 Start-up Command Sequencer

This block sits on the controller side of a DDR2 memory interface and owns the opening stretch of the memory bring-up. After a synchronous reset it holds the clock-enable pin low and keeps a no-operation command on the bus until the system reports that power and clock are stable. It then runs a fixed series of steps:

- a long wait with clock-enable low,
- a shorter wait with clock-enable high,
- a precharge of every bank,
- a write to extended mode register 2,
- a write to extended mode register 3.

When the last register write has gone out, it raises a completion flag. Later mode-register programming and calibration belong to other logic, which waits on that flag.

Each wait length is a parameter in nanoseconds. The block turns it into whole clock cycles by rounding up against the clock-period parameter. The settle time between two back-to-back commands is a plain cycle-count parameter. Every cycle that carries none of the three commands drives a no-operation with bank and address at zero. On-die termination is held off for the whole sequence.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is active, and after reset until `clk_stable_i` is sampled high, `cke_o`=0 and `done_o`=0. The bus carries a no-operation, with `cs_n_o`=0, `ras_n_o`=1, `cas_n_o`=1, `we_n_o`=1, `ba_o`=0 and `addr_o`=0.
- R2: The clock edge that first samples `clk_stable_i` high starts the power-up wait. This wait lasts N_PWR = ceil(T_PWRUP_NS*1000/CLK_PERIOD_PS) cycles, each with `cke_o`=0 and a no-operation. `cke_o` rises in the cycle right after the wait.
- R3: After `cke_o` rises, exactly N_CKE = ceil(T_CKE_NS*1000/CLK_PERIOD_PS) cycles pass with `cke_o`=1 and a no-operation. Only then does any command appear.
- R4: The next cycle carries a precharge of all banks: `ras_n_o`=0, `cas_n_o`=1, `we_n_o`=0, `cs_n_o`=0, `addr_o`=only bit 10 set, `ba_o`=0. It lasts one cycle.
- R5: After GAP_CYC no-operation cycles, one cycle writes extended mode register 2: `ras_n_o`=`cas_n_o`=`we_n_o`=0, `ba_o`=2'b10 (BA1 high, BA0 low), `addr_o`=EMR2_VAL.
- R6: After another GAP_CYC no-operation cycles, one cycle writes extended mode register 3: all three strobes low, `ba_o`=2'b11, `addr_o`=EMR3_VAL.
- R7: `done_o` rises in the cycle right after the register-3 write. It then stays high, with `cke_o`=1 and a no-operation on the bus, until reset.
- R8: `odt_o` is 0 in every cycle.
- R9: A synchronous reset in any state, including mid-wait and after completion, brings back the R1 outputs on the cycle after the reset edge. The sequence then waits for `clk_stable_i` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_stable_i | input | 1 | Power and clock reported stable |
| cke_o | output | 1 | Memory clock enable |
| odt_o | output | 1 | On-die termination enable, held low |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address / op-code |
| done_o | output | 1 | Start-up sequence complete |

## Verification
All outputs are decoded from the registered state. The cycle after the edge that samples `clk_stable_i` high is therefore the first power-up wait cycle. Each later phase follows directly after the one before, with no extra latency: N_PWR cycles, then N_CKE, one precharge, GAP_CYC, one register-2 write, GAP_CYC, one register-3 write, then `done_o`. The bench computes N_PWR and N_CKE itself in real arithmetic. It queues one expected segment per phase at the clock edge that starts the sequence, and compares every cycle at the falling edge. A reset check samples one falling edge after the reset edge.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PWR,
    S_CKE,
    S_PREA,
    S_GAP_A,
    S_EMR2,
    S_GAP_B,
    S_EMR3,
    S_DONE
  } init_state_e;

  // Whole cycles covering a time in ns, rounded up
  function automatic int unsigned wait_cycles(input int unsigned t_ns,
                                              input int unsigned period_ps);
    longint unsigned num;
    num = longint'(t_ns) * 1000 + longint'(period_ps) - 1;
    return int'(num / longint'(period_ps));
  endfunction

  // Bits needed to hold values 0..v
  function automatic int unsigned cnt_bits(input int unsigned v);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= v) w++;
    return w;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R2: a loaded count never wraps; it drains one per cycle
  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/init_cmd_encoder.sv
module init_cmd_encoder
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned BA_W     = 2,
  parameter logic [ADDR_W-1:0] EMR2_VAL = '0,
  parameter logic [ADDR_W-1:0] EMR3_VAL = '0
) (
  input  init_state_e       state,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  always_comb begin
    cke   = 1'b1;
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    ba    = '0;
    addr  = '0;
    unique case (state)
      S_IDLE, S_PWR: cke = 1'b0;
      S_PREA: begin
        ras_n = 1'b0;
        we_n  = 1'b0;
        addr  = ALL_BANKS;
      end
      S_EMR2: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        ba    = BA_W'(2);
        addr  = EMR2_VAL;
      end
      S_EMR3: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        ba    = BA_W'(3);
        addr  = EMR3_VAL;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned T_PWRUP_NS    = 200000,
  parameter int unsigned T_CKE_NS      = 400,
  parameter int unsigned GAP_CYC       = 2,
  parameter logic [12:0] EMR2_VAL      = 13'h000,
  parameter logic [12:0] EMR3_VAL      = 13'h000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clk_stable_i,
  output logic        cke_o,
  output logic        odt_o,
  output logic        cs_n_o,
  output logic        ras_n_o,
  output logic        cas_n_o,
  output logic        we_n_o,
  output logic [1:0]  ba_o,
  output logic [12:0] addr_o,
  output logic        done_o
);
  localparam int unsigned N_PWR = wait_cycles(T_PWRUP_NS, CLK_PERIOD_PS);
  localparam int unsigned N_CKE = wait_cycles(T_CKE_NS, CLK_PERIOD_PS);
  localparam int unsigned N_GAP = (GAP_CYC < 1) ? 1 : GAP_CYC;
  localparam int unsigned CNT_W = cnt_bits(max3(N_PWR, N_CKE, N_GAP));

  init_state_e      state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: if (clk_stable_i) begin
        state_d  = S_PWR;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_PWR - 1);
      end
      S_PWR: if (tmr_expired) begin
        state_d  = S_CKE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_CKE - 1);
      end
      S_CKE:   if (tmr_expired) state_d = S_PREA;
      S_PREA: begin
        state_d  = S_GAP_A;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_GAP - 1);
      end
      S_GAP_A: if (tmr_expired) state_d = S_EMR2;
      S_EMR2: begin
        state_d  = S_GAP_B;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_GAP - 1);
      end
      S_GAP_B: if (tmr_expired) state_d = S_EMR3;
      S_EMR3:  state_d = S_DONE;
      default: state_d = S_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  init_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  init_cmd_encoder #(
    .ADDR_W   (13),
    .BA_W     (2),
    .EMR2_VAL (EMR2_VAL),
    .EMR3_VAL (EMR3_VAL)
  ) u_enc (
    .state (state_q),
    .cke   (cke_o),
    .cs_n  (cs_n_o),
    .ras_n (ras_n_o),
    .cas_n (cas_n_o),
    .we_n  (we_n_o),
    .ba    (ba_o),
    .addr  (addr_o)
  );

  assign odt_o  = 1'b0;
  assign done_o = (state_q == S_DONE);

  // Named bus events for the properties
  wire cmd_pre  = !cs_n_o && !ras_n_o &&  cas_n_o && !we_n_o;
  wire cmd_mrs  = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;
  wire cmd_emr3 = cmd_mrs && (ba_o == 2'b11);

  // R4: precharge-all only with clock enable already high, bit 10 set
  a_r4_prea_after_cke: assert property (@(posedge clk) disable iff (rst)
    cmd_pre |-> ($past(cke_o) && addr_o[10]));
  // R7: completion follows the register-3 write
  a_r7_done_after_emr3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(cmd_emr3));
  // R7: completion is sticky
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
  // R3: clock enable never falls without reset
  a_r3_cke_no_fall: assert property (@(posedge clk) disable iff (rst)
    cke_o |=> cke_o);
  // R5: mode writes only with clock enable high
  a_r5_mrs_cke_high: assert property (@(posedge clk) disable iff (rst)
    cmd_mrs |-> (cke_o && $past(cke_o)));
endmodule

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;
  localparam int unsigned GAP = 2;
  localparam logic [12:0] E2 = 13'h0123;
  localparam logic [12:0] E3 = 13'h0A5A;
  // Independent derivation: 200 us and 400 ns at a 5 ns clock
  localparam int N_PWR = int'($ceil(200.0e-6 / 5.0e-9));
  localparam int N_CKE = int'($ceil(400.0e-9 / 5.0e-9));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_stable_i = 1'b0;
  logic cke_o, odt_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;

  always #2.5 clk = ~clk;

  ddr2_init_seq #(
    .CLK_PERIOD_PS(5000), .T_PWRUP_NS(200000), .T_CKE_NS(400),
    .GAP_CYC(GAP), .EMR2_VAL(E2), .EMR3_VAL(E3)
  ) dut (
    .clk(clk), .rst(rst), .clk_stable_i(clk_stable_i),
    .cke_o(cke_o), .odt_o(odt_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o),
    .done_o(done_o)
  );

  typedef struct {
    logic [21:0] v;
    int          left;
    string       tag;
    bit          bad;
  } seg_t;

  seg_t q[$];
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_MRS = 4'b0000;

  function automatic logic [21:0] mk(input bit cke, input logic [3:0] cmd,
                                     input logic [1:0] ba, input logic [12:0] a,
                                     input bit dn);
    return {1'b0, cke, cmd, ba, a, dn};
  endfunction

  function automatic logic [21:0] actual();
    return {odt_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ba_o, addr_o, done_o};
  endfunction

  task automatic push(input logic [21:0] v, input int n, input string tag);
    seg_t s;
    s.v = v; s.left = n; s.tag = tag; s.bad = 1'b0;
    q.push_back(s);
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
  endtask

  // Monitor: one comparison per cycle, one check per segment
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        seg_t s;
        s = q[0];
        if (actual() !== s.v && !s.bad) begin
          $display("FAIL %s: actual %h expected %h at %0t", s.tag, actual(), s.v, $time);
          s.bad = 1'b1;
        end
        s.left--;
        if (s.left == 0) begin
          void'(q.pop_front());
          tests++;
          if (s.bad) fails++;
        end else begin
          q[0] = s;
        end
      end
    end
  end

  task automatic check_now(input string tag, input logic [21:0] exp);
    tests++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, actual(), exp);
    end
  endtask

  // Driver: raise stability and queue the whole expected trace
  task automatic start_full(input int tail);
    @(negedge clk);
    clk_stable_i = 1'b1;
    @(posedge clk);
    push(mk(0, C_NOP, 2'b00, 13'h0, 0), N_PWR, "R2 cke-low wait");
    push(mk(1, C_NOP, 2'b00, 13'h0, 0), N_CKE, "R3 cke-high wait");
    push(mk(1, C_PRE, 2'b00, 13'h400, 0), 1, "R4 precharge all");
    push(mk(1, C_NOP, 2'b00, 13'h0, 0), GAP, "R5 gap before EMR2");
    push(mk(1, C_MRS, 2'b10, E2, 0), 1, "R5 EMR2 write");
    push(mk(1, C_NOP, 2'b00, 13'h0, 0), GAP, "R6 gap before EMR3");
    push(mk(1, C_MRS, 2'b11, E3, 0), 1, "R6 EMR3 write");
    push(mk(1, C_NOP, 2'b00, 13'h0, 1), tail, "R7 done held, R8 odt low");
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    clk_stable_i = 1'b0;
    @(negedge clk);
    check_now(tag, mk(0, C_NOP, 2'b00, 13'h0, 0));
    rst = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_now("R1 outputs during reset", mk(0, C_NOP, 2'b00, 13'h0, 0));
    rst = 1'b0;
    @(posedge clk);
    push(mk(0, C_NOP, 2'b00, 13'h0, 0), 12, "R1 idle until clk_stable");
    drain();

    // Partial run, then reset while clock enable is high
    @(negedge clk);
    clk_stable_i = 1'b1;
    @(posedge clk);
    push(mk(0, C_NOP, 2'b00, 13'h0, 0), N_PWR, "R2 cke-low wait (run 1)");
    push(mk(1, C_NOP, 2'b00, 13'h0, 0), 20, "R3 cke-high (run 1)");
    drain();
    do_reset("R9 reset mid cke-high wait");
    push(mk(0, C_NOP, 2'b00, 13'h0, 0), 5, "R9 idle again after reset");
    drain();

    // Full run to completion
    start_full(8);
    drain();

    // Reset after completion
    do_reset("R9 reset after done");
    push(mk(0, C_NOP, 2'b00, 13'h0, 0), 4, "R9 R1 idle after done reset");
    drain();
    summary();
  end

  initial begin
    #1000000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule